// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a memory-mapped general-purpose I/O controller for a pin count that is a multiple of 32. Each pin has a direction bit, an output latch and an input path. The input path runs through a two-flop synchroniser. Software reads the pin levels, sets the directions, and drives the outputs high or low through separate write-one set and clear registers, so it never needs a read-modify-write cycle.

Each pin has a rising-edge enable and a falling-edge enable. An enabled transition on the synchronised input sets the pin's sticky status bit. Software clears a status bit by writing a 1 to it. A single interrupt line stays high while any status bit is set.

The registers are arranged by feature. Each feature holds one 32-bit word per group of 32 pins, and the words of one feature sit next to each other. Accesses use a simple synchronous port: a write is taken on the clock edge, and a read returns data combinationally from the address.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: With G = NPINS/32, the word for feature F and pin p sits at byte offset F*G*4 + (p/32)*4, and pin p is bit p%32 of that word. The feature indices are 0 level, 1 direction, 2 output set, 3 output clear, 4 rising enable, 5 falling enable and 6 edge status.
- R2: After reset every register is zero. All pins are inputs (`pin_oe` all 0), `pin_out` is all 0 and `irq` is low.
- R3: The direction word can be read and written. A 1 makes the pin an output, and `pin_oe` follows the stored bit one cycle after the write.
- R4: Writing a 1 to a set bit drives that pin's `pin_out` high. Writing a 1 to a clear bit drives it low. Zero bits in either write leave the latch unchanged. The set and clear words read as zero.
- R5: The level word returns each pin's input after two clock edges of synchronisation, whatever the pin's direction. Writes to the level word are ignored.
- R6: When a pin's rising enable is set, a low-to-high input transition sets its status bit. The status bit and `irq` are visible three clock edges after the pin changes.
- R7: When a pin's falling enable is set, a high-to-low transition sets its status bit. With both enables set, either edge sets it. With the matching enable clear, an edge sets nothing.
- R8: Writing 1 to a status bit clears it, and 0 bits leave their status bits alone, so writing back the value just read clears exactly those bits. `irq` is high while any status bit is 1.
- R9: When a new edge event and a clear of the same status bit fall in the same cycle, the bit stays set.
- R10: Byte offsets at or beyond 7*G*4 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, taken on the rising edge |
| addr | input | AW | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pin_in | input | NPINS | Pin input levels, asynchronous |
| pin_out | output | NPINS | Output latch |
| pin_oe | output | NPINS | Output enable, 1 = drive |
| irq | output | 1 | OR of all edge status bits |

## Verification
A corrupted direction or output latch shows at once on `pin_oe` or `pin_out`, in the cycle after the faulty write or spontaneous change. A wrong synchroniser or previous-value register moves the status update away from its exact third edge, so `irq` rises a cycle early, a cycle late or not at all. Errors in status clearing show when the status word is read back and when `irq` fails to fall. A lost edge colliding with a clear shows when `irq` drops in the cycle after that write.

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl #(
  parameter int NPINS = 64,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);
  localparam int NGRP  = NPINS / 32;
  localparam int NREGS = 7 * NGRP;

  logic [NPINS-1:0] sync1, sync2, prev;
  logic [NPINS-1:0] dir, olat, rise_en, fall_en, status;
  logic [NPINS-1:0] wvec, gmask, ev;
  int unsigned widx, feat, grp;
  logic hit, wr_hit;

  assign widx   = 32'(addr[AW-1:2]);
  assign hit    = widx < NREGS;
  assign feat   = widx / NGRP;
  assign grp    = widx % NGRP;
  assign wr_hit = wr_en && hit;

  always_comb begin
    wvec  = '0;
    gmask = '0;
    if (hit) begin
      wvec[grp*32 +: 32]  = wdata;
      gmask[grp*32 +: 32] = '1;
    end
  end

  assign ev = (sync2 & ~prev & rise_en) | (~sync2 & prev & fall_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1   <= '0;
      sync2   <= '0;
      prev    <= '0;
      dir     <= '0;
      olat    <= '0;
      rise_en <= '0;
      fall_en <= '0;
      status  <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      prev  <= sync2;
      if (wr_hit && feat == 1) dir     <= (dir & ~gmask) | wvec;
      if (wr_hit && feat == 2) olat    <= olat | wvec;
      if (wr_hit && feat == 3) olat    <= olat & ~wvec;
      if (wr_hit && feat == 4) rise_en <= (rise_en & ~gmask) | wvec;
      if (wr_hit && feat == 5) fall_en <= (fall_en & ~gmask) | wvec;
      if (wr_hit && feat == 6) status  <= (status & ~wvec) | ev;
      else                     status  <= status | ev;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit) begin
      case (feat)
        0: rdata = sync2[grp*32 +: 32];
        1: rdata = dir[grp*32 +: 32];
        4: rdata = rise_en[grp*32 +: 32];
        5: rdata = fall_en[grp*32 +: 32];
        6: rdata = status[grp*32 +: 32];
        default: rdata = '0;
      endcase
    end
  end

  assign pin_out = olat;
  assign pin_oe  = dir;
  assign irq     = |status;
endmodule

module gpio_bank_ctrl_chk #(
  parameter int NPINS = 64,
  parameter int AW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [AW-1:0]    addr,
  input logic [31:0]      wdata,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] pin_oe,
  input logic             irq
);
  localparam int G = NPINS / 32;
  localparam logic [AW-1:0] SET0 = AW'(2 * G * 4);
  localparam logic [AW-1:0] CLR0 = AW'(3 * G * 4);

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0 && !irq)); // R2
  AST_OE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pin_oe)); // R3
  AST_SET_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == SET0 && wdata[0]) |=> pin_out[0]); // R4
  AST_CLR_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == CLR0 && wdata[0]) |=> !pin_out[0]); // R4
  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pin_out)); // R4
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_en) |=> irq); // R8
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

// File: tb/sim_gpio_bank_ctrl.sv
module sim_gpio_bank_ctrl;
  localparam int NPINS = 64;
  localparam int AW    = 8;
  // G = 2: level 0/4, dir 8/12, set 16/20, clr 24/28, rise 32/36, fall 40/44, status 48/52
  localparam logic [AW-1:0] A_LVL = 0, A_DIR = 8, A_SET = 16, A_CLR = 24,
                            A_RISE = 32, A_FALL = 40, A_STAT = 48;

  logic clk = 0, rst_n = 0, wr_en = 0, irq;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NPINS-1:0] pin_in = '0, pin_out, pin_oe;
  int errors = 0, checks = 0;
  logic [31:0] v;

  always #2 clk = ~clk;

  gpio_bank_ctrl #(.NPINS(NPINS), .AW(AW)) u0 (.*);

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic do_reset();
    pin_in = '0;
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R2 pin_oe", pin_oe, '0);
    chk("R2 pin_out", pin_out, '0);
    chk("R2 irq", irq, 0);
    rd(A_DIR + 4, v); chk("R2 dir hi", v, 0);
    rd(A_RISE, v);    chk("R2 rise", v, 0);
  endtask

  task automatic t_dir();
    do_reset();
    wr(A_DIR + 4, 32'h0000_8001);
    chk("R3 R1 pin_oe grp1", pin_oe, 64'h0000_8001_0000_0000);
    rd(A_DIR + 4, v); chk("R3 readback", v, 32'h0000_8001);
    wr(A_DIR, 32'h0000_00F0);
    chk("R3 both groups", pin_oe, 64'h0000_8001_0000_00F0);
  endtask

  task automatic t_setclr();
    do_reset();
    wr(A_SET, 32'h0000_0005);
    chk("R4 set", pin_out, 64'h5);
    wr(A_SET + 4, 32'h0000_0002);
    chk("R4 R1 set grp1", pin_out, 64'h0000_0002_0000_0005);
    wr(A_CLR, 32'h0000_0001);
    chk("R4 clear", pin_out, 64'h0000_0002_0000_0004);
    wr(A_CLR, 32'h0);
    wr(A_SET, 32'h0);
    chk("R4 zero writes", pin_out, 64'h0000_0002_0000_0004);
    rd(A_SET, v); chk("R4 set reads 0", v, 0);
    rd(A_CLR + 4, v); chk("R4 clr reads 0", v, 0);
  endtask

  task automatic t_level();
    do_reset();
    wr(A_DIR, 32'h20);
    @(negedge clk); pin_in[33] = 1; pin_in[5] = 1;
    @(negedge clk); addr = A_LVL + 4; #1 chk("R5 one edge not yet", rdata, 0);
    @(negedge clk); addr = A_LVL + 4; #1 chk("R5 after two edges", rdata, 32'h2);
    rd(A_LVL, v); chk("R5 output pin level", v, 32'h20);
    wr(A_LVL, 32'hFFFF_FFFF);
    rd(A_LVL, v); chk("R5 write ignored", v, 32'h20);
  endtask

  task automatic t_rise();
    do_reset();
    wr(A_RISE, 32'h8);
    @(negedge clk); pin_in[3] = 1;
    @(negedge clk); @(negedge clk);
    chk("R6 irq not before 3 edges", irq, 0);
    @(negedge clk);
    chk("R6 irq at third edge", irq, 1);
    rd(A_STAT, v); chk("R6 status", v, 32'h8);
    wr(A_STAT, v);
    chk("R8 irq clears", irq, 0);
    @(negedge clk); pin_in[3] = 0;
    repeat (5) @(negedge clk);
    chk("R7 falling without enable", irq, 0);
  endtask

  task automatic t_both();
    do_reset();
    wr(A_RISE + 4, 32'h8);
    wr(A_FALL + 4, 32'h8);
    @(negedge clk); pin_in[35] = 1;
    repeat (4) @(negedge clk);
    rd(A_STAT + 4, v); chk("R7 rise with both", v, 32'h8);
    wr(A_STAT + 4, 32'h8);
    rd(A_STAT + 4, v); chk("R8 cleared", v, 0);
    @(negedge clk); pin_in[35] = 0;
    repeat (4) @(negedge clk);
    rd(A_STAT + 4, v); chk("R7 fall with both", v, 32'h8);
    do_reset();
    wr(A_FALL, 32'h4);
    @(negedge clk); pin_in[2] = 1;
    repeat (4) @(negedge clk);
    chk("R7 fall-only ignores rise", irq, 0);
    @(negedge clk); pin_in[2] = 0;
    repeat (4) @(negedge clk);
    rd(A_STAT, v); chk("R7 fall-only", v, 32'h4);
  endtask

  task automatic t_w1c();
    do_reset();
    wr(A_RISE, 32'h18);
    @(negedge clk); pin_in[3] = 1; pin_in[4] = 1;
    repeat (4) @(negedge clk);
    rd(A_STAT, v); chk("R8 two bits", v, 32'h18);
    wr(A_STAT, 32'h8);
    rd(A_STAT, v); chk("R8 partial clear", v, 32'h10);
    chk("R8 irq still high", irq, 1);
    wr(A_STAT, v);
    rd(A_STAT, v); chk("R8 writeback clears", v, 0);
    chk("R8 irq low", irq, 0);
  endtask

  task automatic t_collide();
    do_reset();
    wr(A_RISE, 32'h40);
    wr(A_FALL, 32'h40);
    @(negedge clk); pin_in[6] = 1;
    repeat (4) @(negedge clk);
    chk("R9 setup", irq, 1);
    @(negedge clk); pin_in[6] = 0;
    @(negedge clk);
    @(negedge clk); wr_en = 1; addr = A_STAT; wdata = 32'h40;
    @(negedge clk); wr_en = 0;
    chk("R9 edge wins over clear", irq, 1);
    wr(A_STAT, 32'h40);
    chk("R9 later clear", irq, 0);
  endtask

  task automatic t_range();
    do_reset();
    wr(A_DIR, 32'h3);
    wr(8'd56, 32'hFFFF_FFFF);
    wr(8'd252, 32'hFFFF_FFFF);
    chk("R10 writes ignored oe", pin_oe, 64'h3);
    chk("R10 writes ignored out", pin_out, 64'h0);
    rd(8'd56, v); chk("R10 read 56", v, 0);
    rd(8'd252, v); chk("R10 read 252", v, 0);
    rd(A_DIR, v); chk("R10 R1 dir intact", v, 32'h3);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_dir();
    t_setclr();
    t_level();
    t_rise();
    t_both();
    t_w1c();
    t_collide();
    t_range();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule